// File: doc/BRIEF.md
# ADC Trigger Control and Status Register

This block holds the 16-bit control word that a host bus uses to set up acquisition triggering for an ADC path. It also contains the small trigger engine that the word drives. The host selects a trigger source: none, a software strobe, or an external digital line. In software mode, each cycle in which the start strobe is high produces a start pulse toward the paced conversion logic.

In external mode, with the separate external-enable bit also set, the line is first passed through a synchronizer. A rising edge then sets a sticky trigger latch and produces one start pulse. Later edges do nothing until the host writes the self-clearing clear bit. If that clear write lands in the same cycle as a qualifying edge, the clear wins and the edge is dropped.

The burst, pre-trigger, arm, FIFO-mode and counter-source bits are stored and driven out unchanged to neighbouring logic. Software should keep the source field at 0 while it sets up the pacer.

Top module: `adc_trig_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every stored bit and the trigger latch, so rd_data reads 0x0000 and start_pulse is 0.
- R2: A write stores bits 1:0, 4, 5, 6, 11, 12 and 13 of wr_data, and the next read returns them at the same positions. Bits 2, 3, 8, 9, 10 and 14 read 0, bit 7 reads 0, and bit 15 reads the trigger latch state.
- R3: The source field at bits 1:0 decodes as 0 = disabled, 1 = software, 2 = external and 3 = reserved. Disabled and reserved never produce a start pulse.
- R4: With source 1, each cycle in which sw_start is high yields start_pulse high one cycle later. sw_start has no effect under any other source.
- R5: An external trigger needs both source 2 and the external-enable bit (bit 4) set. With either one missing, ext_trig_in has no effect on the latch or on start_pulse.
- R6: ext_trig_in passes through a two-flop synchronizer and only a rising edge qualifies. On the third clock edge after the input rises, the latch sets and start_pulse is high for exactly one cycle. A level held high does not re-trigger.
- R7: While the latch is set, further rising edges on ext_trig_in produce no start pulse.
- R8: Writing 1 to bit 7 clears the latch, and the latch then re-arms for a new rising edge. Writing 0 to bit 7 leaves the latch unchanged.
- R9: When a clear write and a qualifying edge fall in the same cycle, the latch stays clear and no start pulse is issued.
- R10: burst_en, pretrig_en, arm_en, fifo_mode and ctr0_src follow stored bits 5, 6, 11, 12 and 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Register readback including latch status at bit 15 |
| ext_trig_in | input | 1 | Asynchronous external digital trigger |
| sw_start | input | 1 | Software start strobe |
| start_pulse | output | 1 | Start request to paced conversion logic |
| burst_en | output | 1 | Burst mode enable |
| pretrig_en | output | 1 | Pre-trigger mode enable |
| arm_en | output | 1 | Arm bit for FIFO operation |
| fifo_mode | output | 1 | FIFO mode bit |
| ctr0_src | output | 1 | Counter-0 source select |
| trig_latched | output | 1 | Sticky external trigger latch |

## Verification
The bench lands a clear write exactly on the cycle the synchronized edge becomes visible. A design that let the edge win would read bit 15 as 1 and fire a start. It holds the external line high across a clear to catch a level-sensitive detector that re-fires, and it pulses the line again while the latch is set to catch a non-sticky latch. It also tries each gating case: external with enable off, enable with software source, the reserved source, and a software strobe under external mode. A loosely decoded source field or a missing enable gate would show up as a spurious start pulse.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int REG_W      = 16;
  localparam int SRC_LO     = 0;
  localparam int SRC_HI     = 1;
  localparam int EXT_EN_BIT = 4;
  localparam int BURST_BIT  = 5;
  localparam int PRE_BIT    = 6;
  localparam int CLR_BIT    = 7;
  localparam int ARM_BIT    = 11;
  localparam int FIFO_BIT   = 12;
  localparam int C0_BIT     = 13;
  localparam int STAT_BIT   = 15;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_SW   = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_RSVD = 2'd3
  } trig_src_e;

  typedef struct packed {
    trig_src_e src;
    logic      ext_en;
    logic      burst;
    logic      pretrig;
    logic      arm;
    logic      fifo_mode;
    logic      ctr0_src;
  } ctrl_t;
endpackage

// File: rtl/adc_trig_regs.sv
module adc_trig_regs
  import adc_trig_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output ctrl_t        ctrl,
  output logic         clr_strobe
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q.src       <= trig_src_e'(wr_data[SRC_HI:SRC_LO]);
      ctrl_q.ext_en    <= wr_data[EXT_EN_BIT];
      ctrl_q.burst     <= wr_data[BURST_BIT];
      ctrl_q.pretrig   <= wr_data[PRE_BIT];
      ctrl_q.arm       <= wr_data[ARM_BIT];
      ctrl_q.fifo_mode <= wr_data[FIFO_BIT];
      ctrl_q.ctr0_src  <= wr_data[C0_BIT];
    end
  end

  // The clear bit acts only on the write cycle and is never stored.
  assign clr_strobe = wr_en & wr_data[CLR_BIT];
  assign ctrl       = ctrl_q;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[W-1:C0_BIT+1], wr_data[ARM_BIT-1:CLR_BIT+1],
                            wr_data[EXT_EN_BIT-1:SRC_HI+1]};
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[LAST];
  end

  assign rise = chain[LAST] & ~prev_q;
endmodule

// File: rtl/adc_trig_latch.sv
module adc_trig_latch
  import adc_trig_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  trig_src_e src,
  input  logic      ext_en,
  input  logic      ext_rise,
  input  logic      clr,
  input  logic      sw_start,
  output logic      latched,
  output logic      start
);
  logic ext_armed;
  logic set_now;
  logic sw_fire;

  assign ext_armed = (src == SRC_EXT) && ext_en;
  // A clear in the same cycle suppresses the edge.
  assign set_now   = ext_armed && ext_rise && !latched && !clr;
  assign sw_fire   = (src == SRC_SW) && sw_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      latched <= 1'b0;
      start   <= 1'b0;
    end else begin
      if (clr)          latched <= 1'b0;
      else if (set_now) latched <= 1'b1;
      start <= set_now | sw_fire;
    end
  end
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int W           = REG_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         ext_trig_in,
  input  logic         sw_start,
  output logic         start_pulse,
  output logic         burst_en,
  output logic         pretrig_en,
  output logic         arm_en,
  output logic         fifo_mode,
  output logic         ctr0_src,
  output logic         trig_latched
);
  ctrl_t ctrl;
  logic  clr_strobe;
  logic  ext_rise;

  adc_trig_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl(ctrl), .clr_strobe(clr_strobe)
  );

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(ext_trig_in), .rise(ext_rise)
  );

  adc_trig_latch u_latch (
    .clk(clk), .rst(rst), .src(ctrl.src), .ext_en(ctrl.ext_en),
    .ext_rise(ext_rise), .clr(clr_strobe), .sw_start(sw_start),
    .latched(trig_latched), .start(start_pulse)
  );

  always_comb begin
    rd_data                  = '0;
    rd_data[SRC_HI:SRC_LO]   = ctrl.src;
    rd_data[EXT_EN_BIT]      = ctrl.ext_en;
    rd_data[BURST_BIT]       = ctrl.burst;
    rd_data[PRE_BIT]         = ctrl.pretrig;
    rd_data[ARM_BIT]         = ctrl.arm;
    rd_data[FIFO_BIT]        = ctrl.fifo_mode;
    rd_data[C0_BIT]          = ctrl.ctr0_src;
    rd_data[STAT_BIT]        = trig_latched;
  end

  assign burst_en   = ctrl.burst;
  assign pretrig_en = ctrl.pretrig;
  assign arm_en     = ctrl.arm;
  assign fifo_mode  = ctrl.fifo_mode;
  assign ctr0_src   = ctrl.ctr0_src;
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        ext_trig_in,
  input logic        sw_start,
  input logic        start_pulse,
  input logic        burst_en,
  input logic        pretrig_en,
  input logic        arm_en,
  input logic        fifo_mode,
  input logic        ctr0_src,
  input logic        trig_latched
);
  localparam logic [15:0] KEEP = 16'h3873;

  logic unused_ext;
  assign unused_ext = ext_trig_in;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (rd_data == 16'h0000 && !start_pulse));

  assert_write_store_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(wr_data[7] === 1'bx)) |=> ((rd_data & KEEP) == ($past(wr_data) & KEEP)));

  assert_start_cause_R4: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> (($past(rd_data[1:0]) == 2'd1 && $past(sw_start)) || $rose(trig_latched)));

  assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (!(rd_data[1:0] == 2'd2 && rd_data[4]) && !trig_latched) |=> !trig_latched);

  assert_set_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_latched) |-> start_pulse);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (trig_latched && !(wr_en && wr_data[7])) |=> trig_latched);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[7]) |=> !trig_latched);

  assert_mirror_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ({burst_en, pretrig_en, arm_en, fifo_mode, ctr0_src} ==
               {$past(wr_data[5]), $past(wr_data[6]), $past(wr_data[11]),
                $past(wr_data[12]), $past(wr_data[13])}));
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk u_chk (.*);

// File: tb/adc_trig_ctrl_bench.sv
module adc_trig_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        ext_trig_in = 1'b0;
  logic        sw_start = 1'b0;
  logic [15:0] rd_data;
  logic        start_pulse, burst_en, pretrig_en, arm_en, fifo_mode, ctr0_src, trig_latched;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string       req;
    logic [15:0] rd;
    logic        start;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  adc_trig_ctrl u_adc_trig_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ext_trig_in(ext_trig_in), .sw_start(sw_start), .start_pulse(start_pulse),
    .burst_en(burst_en), .pretrig_en(pretrig_en), .arm_en(arm_en),
    .fifo_mode(fifo_mode), .ctr0_src(ctr0_src), .trig_latched(trig_latched)
  );

  // Monitor: compares after each falling edge.
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      exp_t e;
      logic [4:0] fl_exp;
      e = sb.pop_front();
      fl_exp = {e.rd[5], e.rd[6], e.rd[11], e.rd[12], e.rd[13]};
      checks++;
      if (rd_data !== e.rd || start_pulse !== e.start || trig_latched !== e.rd[15] ||
          {burst_en, pretrig_en, arm_en, fifo_mode, ctr0_src} !== fl_exp) begin
        fails++;
        $display("FAIL %s: rd=%h start=%b flags=%b latched=%b, expected rd=%h start=%b flags=%b",
                 e.req, rd_data, start_pulse,
                 {burst_en, pretrig_en, arm_en, fifo_mode, ctr0_src}, trig_latched,
                 e.rd, e.start, fl_exp);
      end
    end
  end

  // Driver: wait for the next edge, then push what must be seen.
  task automatic step(input string req, input logic [15:0] rd, input logic st);
    exp_t e;
    @(negedge clk);
    e.req = req; e.rd = rd; e.start = st;
    sb.push_back(e);
  endtask

  task automatic write_reg(input logic [15:0] v, input logic [15:0] rd, input string req);
    wr_en = 1'b1; wr_data = v;
    step(req, rd, 1'b0);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n, input logic [15:0] rd, input string req);
    for (int i = 0; i < n; i++) step(req, rd, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    step("R1 reset", 16'h0000, 1'b0);
    rst = 1'b0;
    step("R1 after reset", 16'h0000, 1'b0);

    // All ones: only stored bits come back, source becomes reserved.
    write_reg(16'hFFFF, 16'h3873, "R2 R10 write all ones");
    sw_start = 1'b1;
    step("R3 reserved source ignores sw", 16'h3873, 1'b0);
    sw_start = 1'b0;
    ext_trig_in = 1'b1;
    idle(4, 16'h3873, "R3 reserved source ignores ext");
    ext_trig_in = 1'b0;
    idle(3, 16'h3873, "R3 settle");

    // Software source.
    write_reg(16'h0001, 16'h0001, "R2 software source");
    sw_start = 1'b1;
    step("R4 sw start pulse", 16'h0001, 1'b1);
    step("R4 sw held second cycle", 16'h0001, 1'b1);
    sw_start = 1'b0;
    step("R4 sw pulse ends", 16'h0001, 1'b0);

    // Disabled source.
    write_reg(16'h0000, 16'h0000, "R2 disabled");
    sw_start = 1'b1;
    step("R3 disabled ignores sw", 16'h0000, 1'b0);
    sw_start = 1'b0;

    // External source, enable off.
    write_reg(16'h0002, 16'h0002, "R2 ext no enable");
    ext_trig_in = 1'b1;
    idle(4, 16'h0002, "R5 enable off ignores edge");
    ext_trig_in = 1'b0;
    idle(3, 16'h0002, "R5 settle");

    // Enable on, software source.
    write_reg(16'h0011, 16'h0011, "R2 sw with enable");
    ext_trig_in = 1'b1;
    step("R5 sw source ignores edge a", 16'h0011, 1'b0);
    step("R5 sw source ignores edge b", 16'h0011, 1'b0);
    step("R5 sw source ignores edge c", 16'h0011, 1'b0);
    step("R5 sw source ignores edge d", 16'h0011, 1'b0);
    ext_trig_in = 1'b0;
    idle(3, 16'h0011, "R5 settle");

    // Armed external trigger.
    write_reg(16'h0012, 16'h0012, "R2 ext armed");
    sw_start = 1'b1;
    step("R4 sw ignored under ext", 16'h0012, 1'b0);
    sw_start = 1'b0;
    ext_trig_in = 1'b1;
    step("R6 sync stage 1", 16'h0012, 1'b0);
    step("R6 sync stage 2", 16'h0012, 1'b0);
    step("R6 latch and pulse", 16'h8012, 1'b1);
    step("R6 single pulse", 16'h8012, 1'b0);
    idle(2, 16'h8012, "R6 level no retrigger");
    ext_trig_in = 1'b0;
    idle(3, 16'h8012, "R7 low");
    ext_trig_in = 1'b1;
    idle(5, 16'h8012, "R7 second edge ignored");
    ext_trig_in = 1'b0;
    idle(3, 16'h8012, "R7 settle");

    // Clear bit semantics.
    write_reg(16'h0012, 16'h8012, "R8 write zero to clear keeps latch");
    write_reg(16'h0092, 16'h0012, "R8 write one clears latch");

    // Clear collides with a qualifying edge.
    ext_trig_in = 1'b1;
    step("R9 sync stage 1", 16'h0012, 1'b0);
    step("R9 sync stage 2", 16'h0012, 1'b0);
    write_reg(16'h0092, 16'h0012, "R9 clear wins over edge");
    idle(3, 16'h0012, "R6 held level after clear no trigger");
    ext_trig_in = 1'b0;
    idle(3, 16'h0012, "R8 settle");

    // Re-armed: a fresh edge triggers again.
    ext_trig_in = 1'b1;
    step("R8 rearm stage 1", 16'h0012, 1'b0);
    step("R8 rearm stage 2", 16'h0012, 1'b0);
    step("R8 rearmed trigger", 16'h8012, 1'b1);
    step("R8 rearmed single", 16'h8012, 1'b0);
    ext_trig_in = 1'b0;

    // Mode bits with trigger latched, then reset.
    write_reg(16'h1862, 16'h9862, "R10 mode bits 5 6 11 12");
    rst = 1'b1;
    step("R1 reset clears latch", 16'h0000, 1'b0);
    rst = 1'b0;
    step("R1 after second reset", 16'h0000, 1'b0);

    @(negedge clk);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule